// File: doc/BRIEF.md
# SECDED-Guarded Memory Banks with Error Status

This block wraps a set of small synchronous single-port-style RAM banks (one write port and one read port per bank) so that no stored word can be silently corrupted. Every word written is extended with a Hamming code plus an overall parity bit. Every word read back is checked: a single flipped bit is repaired on the read path, and a double flip is flagged as uncorrectable. The repair logic is never switched off, so a double error may come back with extra bits flipped.

The default build has five banks. Each bank stands for one of the storage structures of a switch port: bit 0 is ingress control, bit 1 is ingress data, bit 2 is egress control, bit 3 is egress data and bit 4 is replay control. Each bank owns one sticky status bit. A small register port lets software read and clear the status, mask reporting per error class, and force status bits for handler testing. An injection mask on the write path lets a testbench corrupt stored codewords.

Top module: `ecc_mem_guard`

## Requirements
- R1: A read request to a bank (`re_i` bit high at a clock edge) yields `rvalid_o` for that bank in the following cycle, with `rdata_o` equal to the last word written at that address when no bits were injected, and both error flags low.
- R2: Codeword layout (72 bits for 64 data bits): position 0 holds overall even parity over the whole word, check bit k sits at position 2^k (k = 0..6), and data bits fill the remaining positions 3,5,6,7,9,... up to 71 in ascending order, data bit 0 first. Bit n of `inj_mask_i` inverts codeword position n as it is stored.
- R3: With exactly one codeword bit inverted, the read returns the original data with `sbe_o` high and `dbe_o` low in the `rvalid_o` cycle; an inversion at position 0 counts as a single error.
- R4: With exactly two positions p and q inverted, `dbe_o` is high and `sbe_o` low; correction still acts, so the returned data also has the bit at position p XOR q inverted when that position holds data.
- R5: A detected error that is enabled for reporting sets the status bit of the bank where it occurred one cycle after the flag; status is read at register address 0 and is sticky.
- R6: Register address 2 holds the reporting enables, bit 0 for single errors and bit 1 for double errors, both 1 after reset. A disabled class still pulses its flag but leaves the status unchanged.
- R7: Writing a 1 to a status bit clears it; when an enabled detection and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: Writing a 1 to a bit of the test register (address 1) sets the matching status bit regardless of the enables; address 1 reads as zero.
- R9: `err_o` is high whenever any status bit is set, whether it was set by a real detection or through the test register.
- R10: After reset the status is zero, the enables read 3, and `rvalid_o`, `sbe_o`, `dbe_o` and `err_o` are low.
- R11: Banks are independent: writing, injecting or reading one bank does not change the contents, flags or status bit of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | N_MEM | Per-bank write enable |
| waddr_i | input | AW | Write address shared by all banks |
| wdata_i | input | DATA_W | Write data shared by all banks |
| inj_mask_i | input | CW | Codeword bits to invert on write |
| re_i | input | N_MEM | Per-bank read request |
| raddr_i | input | AW | Read address shared by all banks |
| rdata_o | output | N_MEM*DATA_W | Corrected read data, bank b at bits b*DATA_W upward |
| rvalid_o | output | N_MEM | Read data valid, one cycle after request |
| sbe_o | output | N_MEM | Single error corrected on this read |
| dbe_o | output | N_MEM | Uncorrectable double error on this read |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 status, 1 test, 2 enables |
| reg_wdata_i | input | N_MEM | Register write data |
| reg_rdata_o | output | N_MEM | Register read data for the selected address |
| err_o | output | 1 | Any status bit set |

## Verification
The case where two functions meet in one cycle is a hardware status set from a read that detects an enabled single error, coinciding with a software write-one-to-clear of that same status bit. The bench issues the read so that its flag is up in the cycle in which the clear write is presented, and in the same write also clears a second bit that no detection touches. It judges the outcome by reading status afterwards: the detected bank's bit must remain set while the other bit must be gone.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;

  // Smallest number of Hamming check bits covering dw data bits.
  function automatic int chk_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_TEST   = 2'd1,
    REG_ENABLE = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/secded_encode.sv
module secded_encode #(
  parameter int DW = 64,
  parameter int P  = 7,
  parameter int CW = DW + P + 1
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] code_o
);

  always_comb begin
    logic [CW-1:0] c;
    logic          b;
    int            j;
    c = '0;
    j = 0;
    for (int i = 1; i < CW; i++) begin
      if ((i & (i - 1)) != 0) begin
        c[i] = data_i[j];
        j++;
      end
    end
    for (int k = 0; k < P; k++) begin
      b = 1'b0;
      for (int i = 1; i < CW; i++) begin
        if (((i >> k) & 1) == 1) b = b ^ c[i];
      end
      c[1 << k] = b;
    end
    c[0]   = ^c;
    code_o = c;
  end

endmodule

// File: rtl/secded_check.sv
module secded_check #(
  parameter int DW = 64,
  parameter int P  = 7,
  parameter int CW = DW + P + 1
) (
  input  logic          valid_i,
  input  logic [CW-1:0] code_i,
  output logic [DW-1:0] data_o,
  output logic          sbe_o,
  output logic          dbe_o
);

  logic [P-1:0] syn;
  logic         par_bad;
  logic         syn_in_range;

  always_comb begin
    syn = '0;
    for (int i = 1; i < CW; i++) begin
      if (code_i[i]) syn = syn ^ P'(i);
    end
  end

  assign par_bad      = ^code_i;
  assign syn_in_range = int'(syn) < CW;

  // Correction is applied whenever the syndrome names a data position,
  // including on a double detection.
  always_comb begin
    int j;
    j = 0;
    data_o = '0;
    for (int i = 1; i < CW; i++) begin
      if ((i & (i - 1)) != 0) begin
        data_o[j] = code_i[i] ^ (int'(syn) == i);
        j++;
      end
    end
  end

  assign sbe_o = valid_i & par_bad & syn_in_range;
  assign dbe_o = valid_i & (((syn != '0) & ~par_bad) | (par_bad & ~syn_in_range));

endmodule

// File: rtl/ecc_ram_bank.sv
module ecc_ram_bank #(
  parameter int DW    = 64,
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int P     = 7,
  parameter int CW    = DW + P + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [CW-1:0] inj_mask_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          sbe_o,
  output logic          dbe_o
);

  logic [CW-1:0] mem_q [DEPTH];
  logic [CW-1:0] wr_code;
  logic [CW-1:0] rd_q;
  logic          rvalid_q;

  secded_encode #(.DW(DW), .P(P), .CW(CW)) u_enc (
    .data_i (wdata_i),
    .code_o (wr_code)
  );

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wr_code ^ inj_mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q     <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= re_i;
      if (re_i) rd_q <= mem_q[raddr_i];
    end
  end

  secded_check #(.DW(DW), .P(P), .CW(CW)) u_chk (
    .valid_i (rvalid_q),
    .code_i  (rd_q),
    .data_o  (rdata_o),
    .sbe_o   (sbe_o),
    .dbe_o   (dbe_o)
  );

  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/ecc_err_regs.sv
module ecc_err_regs
  import ecc_guard_pkg::*;
#(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sbe_i,
  input  logic [N-1:0] dbe_i,
  input  logic         reg_we_i,
  input  logic [1:0]   reg_addr_i,
  input  logic [N-1:0] reg_wdata_i,
  output logic [N-1:0] reg_rdata_o,
  output logic [N-1:0] status_o,
  output logic [1:0]   en_o,
  output logic         err_o
);

  logic [N-1:0] status_q;
  logic [1:0]   en_q;
  logic [N-1:0] hw_set;
  logic [N-1:0] tst_set;
  logic [N-1:0] sw_clr;
  reg_sel_e     sel;

  assign sel     = reg_sel_e'(reg_addr_i);
  assign hw_set  = (sbe_i & {N{en_q[0]}}) | (dbe_i & {N{en_q[1]}});
  assign tst_set = (reg_we_i && sel == REG_TEST)   ? reg_wdata_i : '0;
  assign sw_clr  = (reg_we_i && sel == REG_STATUS) ? reg_wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      en_q     <= 2'b11;
    end else begin
      // set has priority over clear
      status_q <= (status_q & ~sw_clr) | hw_set | tst_set;
      if (reg_we_i && sel == REG_ENABLE) en_q <= reg_wdata_i[1:0];
    end
  end

  always_comb begin
    unique case (sel)
      REG_STATUS: reg_rdata_o = status_q;
      REG_ENABLE: reg_rdata_o = {{(N-2){1'b0}}, en_q};
      default:    reg_rdata_o = '0;
    endcase
  end

  assign status_o = status_q;
  assign en_o     = en_q;
  assign err_o    = |status_q;

endmodule

// File: rtl/ecc_mem_guard.sv
module ecc_mem_guard
  import ecc_guard_pkg::*;
#(
  parameter int N_MEM  = 5,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int P     = chk_bits(DATA_W),
  localparam int CW    = DATA_W + P + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_MEM-1:0]        we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [CW-1:0]           inj_mask_i,
  input  logic [N_MEM-1:0]        re_i,
  input  logic [AW-1:0]           raddr_i,
  output logic [N_MEM*DATA_W-1:0] rdata_o,
  output logic [N_MEM-1:0]        rvalid_o,
  output logic [N_MEM-1:0]        sbe_o,
  output logic [N_MEM-1:0]        dbe_o,
  input  logic                    reg_we_i,
  input  logic [1:0]              reg_addr_i,
  input  logic [N_MEM-1:0]        reg_wdata_i,
  output logic [N_MEM-1:0]        reg_rdata_o,
  output logic                    err_o
);

  logic [N_MEM-1:0] status_w;
  logic [1:0]       en_w;

  for (genvar b = 0; b < N_MEM; b++) begin : g_bank
    ecc_ram_bank #(
      .DW(DATA_W), .DEPTH(DEPTH), .AW(AW), .P(P), .CW(CW)
    ) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (we_i[b]),
      .waddr_i    (waddr_i),
      .wdata_i    (wdata_i),
      .inj_mask_i (inj_mask_i),
      .re_i       (re_i[b]),
      .raddr_i    (raddr_i),
      .rdata_o    (rdata_o[b*DATA_W +: DATA_W]),
      .rvalid_o   (rvalid_o[b]),
      .sbe_o      (sbe_o[b]),
      .dbe_o      (dbe_o[b])
    );
  end

  ecc_err_regs #(.N(N_MEM)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sbe_i       (sbe_o),
    .dbe_i       (dbe_o),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .status_o    (status_w),
    .en_o        (en_w),
    .err_o       (err_o)
  );

endmodule

// File: rtl/ecc_mem_guard_chk.sv
module ecc_mem_guard_chk #(
  parameter int N = 5
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] re_i,
  input logic [N-1:0] rvalid_o,
  input logic [N-1:0] sbe_o,
  input logic [N-1:0] dbe_o,
  input logic         reg_we_i,
  input logic [1:0]   reg_addr_i,
  input logic [N-1:0] reg_wdata_i,
  input logic [N-1:0] status_i,
  input logic [1:0]   en_i
);

  logic         past_ok;
  logic [N-1:0] evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign evt = (sbe_o & {N{en_i[0]}}) | (dbe_o & {N{en_i[1]}});

  p_rvalid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> rvalid_o == $past(re_i));

  p_flag_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbe_o & dbe_o) == '0);

  p_flag_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sbe_o | dbe_o) & ~rvalid_o) == '0);

  p_status_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt != '0 |=> (status_i & $past(evt)) == $past(evt));

  p_status_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !reg_we_i && evt == '0 |=> $stable(status_i));

  p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 2'd0 && evt == '0 |=> (status_i & $past(reg_wdata_i)) == '0);

  p_test_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 2'd1 |=> (status_i & $past(reg_wdata_i)) == $past(reg_wdata_i));

endmodule

bind ecc_mem_guard ecc_mem_guard_chk #(.N(N_MEM)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .re_i        (re_i),
  .rvalid_o    (rvalid_o),
  .sbe_o       (sbe_o),
  .dbe_o       (dbe_o),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .status_i    (status_w),
  .en_i        (en_w)
);

// File: tb/test_ecc_mem_guard.sv
module test_ecc_mem_guard;

  localparam int N  = 5;
  localparam int DW = 64;
  localparam int AW = 4;
  localparam int CW = 72;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    we_i = '0;
  logic [AW-1:0]   waddr_i = '0;
  logic [DW-1:0]   wdata_i = '0;
  logic [CW-1:0]   inj_mask_i = '0;
  logic [N-1:0]    re_i = '0;
  logic [AW-1:0]   raddr_i = '0;
  logic [N*DW-1:0] rdata_o;
  logic [N-1:0]    rvalid_o, sbe_o, dbe_o;
  logic            reg_we_i = 1'b0;
  logic [1:0]      reg_addr_i = '0;
  logic [N-1:0]    reg_wdata_i = '0;
  logic [N-1:0]    reg_rdata_o;
  logic            err_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  ecc_mem_guard i_ecc_mem_guard (
    .clk_i, .rst_ni, .we_i, .waddr_i, .wdata_i, .inj_mask_i, .re_i, .raddr_i,
    .rdata_o, .rvalid_o, .sbe_o, .dbe_o, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .err_o
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // data index of a codeword position, -1 for parity/check positions (R2)
  function automatic int pos2idx(input int pos);
    int n;
    if (pos <= 0 || (pos & (pos - 1)) == 0) return -1;
    n = 0;
    for (int k = 0; (1 << k) <= pos; k++) n++;
    return pos - n - 1;
  endfunction

  function automatic logic [63:0] flip_at(input logic [63:0] d, input int pos);
    int ix;
    ix = pos2idx(pos);
    if (ix >= 0 && pos < CW) d[ix] = ~d[ix];
    return d;
  endfunction

  task automatic do_write(input int b, input int a, input logic [63:0] d, input logic [CW-1:0] m);
    @(negedge clk_i);
    we_i = '0; we_i[b] = 1'b1; waddr_i = AW'(a); wdata_i = d; inj_mask_i = m;
    @(negedge clk_i);
    we_i = '0; inj_mask_i = '0;
  endtask

  task automatic do_read(input int b, input int a, output logic [63:0] d, output logic rv, output logic sb, output logic db);
    @(negedge clk_i);
    re_i = '0; re_i[b] = 1'b1; raddr_i = AW'(a);
    @(negedge clk_i);
    re_i = '0;
    d = rdata_o[b*DW +: DW]; rv = rvalid_o[b]; sb = sbe_o[b]; db = dbe_o[b];
  endtask

  task automatic reg_wr(input int a, input logic [N-1:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 2'(a); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [N-1:0] d);
    @(negedge clk_i);
    reg_addr_i = 2'(a);
    #1 d = reg_rdata_o;
  endtask

  task automatic t_reset();
    logic [N-1:0] r;
    reg_rd(0, r); chk("R10", "status", 64'(r), 64'h0);
    reg_rd(2, r); chk("R10", "enables", 64'(r), 64'h3);
    chk("R10", "rvalid", 64'(rvalid_o), 64'h0);
    chk("R10", "flags", 64'({sbe_o, dbe_o}), 64'h0);
    chk("R10", "err", 64'(err_o), 64'h0);
  endtask

  task automatic t_clean();
    logic [63:0] d; logic rv, sb, db;
    logic [N-1:0] r;
    do_write(0, 3, 64'hDEAD_BEEF_0123_4567, '0);
    do_write(4, 3, 64'hFFFF_FFFF_FFFF_FFFF, '0);
    do_write(2, 15, 64'h0, '0);
    do_read(0, 3, d, rv, sb, db);
    chk("R1", "data b0", d, 64'hDEAD_BEEF_0123_4567);
    chk("R1", "rvalid", 64'(rv), 64'h1);
    chk("R1", "flags", 64'({sb, db}), 64'h0);
    do_read(4, 3, d, rv, sb, db);
    chk("R11", "data b4", d, 64'hFFFF_FFFF_FFFF_FFFF);
    do_read(2, 15, d, rv, sb, db);
    chk("R1", "data b2 zero", d, 64'h0);
    reg_rd(0, r); chk("R1", "no status", 64'(r), 64'h0);
  endtask

  task automatic t_single();
    logic [63:0] d; logic rv, sb, db;
    logic [N-1:0] r;
    int pos [5] = '{0, 3, 64, 71, 33};
    foreach (pos[i]) begin
      logic [CW-1:0] m;
      m = '0; m[pos[i]] = 1'b1;
      do_write(1, 5, 64'hA5A5_5A5A_C3C3_3C3C ^ 64'(i), m);
      do_read(1, 5, d, rv, sb, db);
      chk("R3", $sformatf("data pos%0d", pos[i]), d, 64'hA5A5_5A5A_C3C3_3C3C ^ 64'(i));
      chk("R3", "sbe", 64'(sb), 64'h1);
      chk("R3", "dbe", 64'(db), 64'h0);
    end
    reg_rd(0, r); chk("R5", "status bit1", 64'(r), 64'h02);
    chk("R9", "err", 64'(err_o), 64'h1);
    reg_wr(0, 5'h02);
    reg_rd(0, r); chk("R7", "w1c clears", 64'(r), 64'h0);
    chk("R9", "err low", 64'(err_o), 64'h0);
  endtask

  task automatic t_double();
    logic [63:0] d, e; logic rv, sb, db;
    logic [N-1:0] r;
    int pa [3] = '{3, 0, 40};
    int pb [3] = '{5, 3, 50};
    foreach (pa[i]) begin
      logic [CW-1:0] m;
      m = '0; m[pa[i]] = 1'b1; m[pb[i]] = 1'b1;
      e = 64'h1357_9BDF_2468_ACE0;
      do_write(3, 7, e, m);
      e = flip_at(e, pa[i]);
      e = flip_at(e, pb[i]);
      e = flip_at(e, pa[i] ^ pb[i]);
      do_read(3, 7, d, rv, sb, db);
      chk("R4", $sformatf("data %0d/%0d", pa[i], pb[i]), d, e);
      chk("R4", "dbe", 64'(db), 64'h1);
      chk("R4", "sbe", 64'(sb), 64'h0);
    end
    reg_rd(0, r); chk("R5", "status bit3", 64'(r), 64'h08);
    reg_wr(0, 5'h1F);
  endtask

  task automatic t_enable();
    logic [63:0] d; logic rv, sb, db;
    logic [N-1:0] r;
    logic [CW-1:0] m;
    reg_wr(2, 5'h02);
    reg_rd(2, r); chk("R6", "enables", 64'(r), 64'h2);
    m = '0; m[20] = 1'b1;
    do_write(0, 1, 64'h55, m);
    do_read(0, 1, d, rv, sb, db);
    chk("R6", "sbe still pulses", 64'(sb), 64'h1);
    reg_rd(0, r); chk("R6", "masked single", 64'(r), 64'h0);
    m[30] = 1'b1;
    do_write(0, 1, 64'h55, m);
    do_read(0, 1, d, rv, sb, db);
    chk("R6", "dbe pulses", 64'(db), 64'h1);
    reg_rd(0, r); chk("R6", "enabled double", 64'(r), 64'h01);
    reg_wr(2, 5'h00);
    reg_wr(0, 5'h01);
    do_read(0, 1, d, rv, sb, db);
    reg_rd(0, r); chk("R6", "masked double", 64'(r), 64'h0);
    reg_wr(2, 5'h03);
  endtask

  task automatic t_test_reg();
    logic [N-1:0] r;
    reg_wr(1, 5'h12);
    reg_rd(0, r); chk("R8", "forced status", 64'(r), 64'h12);
    reg_rd(1, r); chk("R8", "test reads 0", 64'(r), 64'h0);
    chk("R9", "err from test", 64'(err_o), 64'h1);
    reg_wr(0, 5'h12);
    reg_rd(0, r); chk("R7", "cleared", 64'(r), 64'h0);
    chk("R9", "err cleared", 64'(err_o), 64'h0);
  endtask

  task automatic t_collide();
    logic [N-1:0] r;
    logic [CW-1:0] m;
    m = '0; m[9] = 1'b1;
    do_write(1, 2, 64'h77, m);
    reg_wr(1, 5'h08);
    @(negedge clk_i);
    re_i = 5'h02; raddr_i = 4'd2;
    @(negedge clk_i);
    re_i = '0;
    reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 5'h0A;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    reg_rd(0, r); chk("R7", "set wins over clear", 64'(r), 64'h02);
    reg_wr(0, 5'h02);
  endtask

  task automatic t_isolation();
    logic [63:0] d; logic rv, sb, db;
    logic [N-1:0] r;
    logic [CW-1:0] m;
    m = '0; m[45] = 1'b1;
    do_write(4, 9, 64'hCAFE, '0);
    do_write(2, 9, 64'hBEEF, m);
    do_read(4, 9, d, rv, sb, db);
    chk("R11", "b4 clean", d, 64'hCAFE);
    chk("R11", "b4 no flag", 64'(sb), 64'h0);
    do_read(2, 9, d, rv, sb, db);
    chk("R11", "b2 corrected", d, 64'hBEEF);
    reg_rd(0, r); chk("R11", "only bit2", 64'(r), 64'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_clean();
    t_single();
    t_double();
    t_enable();
    t_test_reg();
    t_collide();
    t_isolation();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule